// File: doc/BRIEF.md
# Interrupt Status Set/Clear Aggregator

This block keeps a 32-bit interrupt cause word. Software can set cause bits by writing a mask to a set offset. It can clear cause bits by writing a mask to a clear offset. Internal units can also set bits in any cycle by presenting a set mask, and two named completion strobes map to fixed bit positions. Software reads the cause word back at a status offset.

The block signals the host in one of two ways, chosen by a configuration input.

- **Level mode:** it drives a level-sensitive interrupt line. A raise that leaves the cause word nonzero asserts the line. The line drops only when a clear empties the word.
- **Message mode:** every raise that leaves the word nonzero produces a one-cycle message pulse. The level line is neither raised nor lowered in this mode.

Top module: `intr_status_agg`

## Requirements
- R1: After reset the cause word is zero, `irq_level` is 0 and `msi_pulse` is 0.
- R2: A read at byte offset 0x24 returns the cause word. A read at any other offset returns all ones.
- R3: A write to offset 0x60 ORs `wr_data` into the cause word. The result is visible one cycle later.
- R4: A write to offset 0x64 clears every cause bit that is 1 in `wr_data`. The other bits are kept.
- R5: Internal units raise causes in any cycle. Each 32-bit slice of `unit_set` ORs into the cause word. `calc_done` sets bit 0 and `copy_done` sets bit 8.
- R6: When a clear and a set land in the same cycle, the clear mask is applied first and the set masks after it. A bit that is both cleared and set ends up 1.
- R7: In level mode (`msi_en`=0), a raise whose resulting word is nonzero drives `irq_level` to 1 in the next cycle. A raise is a write to 0x60 of any value, or any nonzero internal set.
- R8: `irq_level` falls only after a write to 0x64 that leaves the word zero while `msi_en` is 0. A partial clear leaves the line at 1.
- R9: In message mode (`msi_en`=1), each raise whose resulting word is nonzero gives `msi_pulse`=1 for exactly the next cycle. Back-to-back raises give back-to-back pulses. `irq_level` keeps its value in this mode.
- R10: Writes to any offset other than 0x60 and 0x64 leave the cause word and both outputs unchanged.
- R11: A raise that leaves the cause word zero produces neither a pulse nor a level assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 20 | Write byte offset |
| wr_data | input | 32 | Write data / mask |
| rd_addr | input | 20 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| calc_done | input | 1 | Computation finished; raises bit 0 |
| copy_done | input | 1 | Transfer finished; raises bit 8 |
| unit_set | input | 96 | Per-cycle set masks, 32 bits per internal unit |
| msi_en | input | 1 | 1 selects message mode, 0 selects level mode |
| irq_level | output | 1 | Level interrupt line |
| msi_pulse | output | 1 | One-cycle message request |

## Verification
The set and clear masks are driven in several patterns:
- Single bits, multi-bit masks and the all-ones mask. These separate OR-merging from overwriting, and a partial clear from a full clear.
- A clear and an internal set aimed at the same bit in one cycle. This exposes the wrong priority order.
- Writes to an unrelated offset and a zero set mask on an empty word. These separate real raises from mere bus activity.

Switching `msi_en` with the line already high shows whether message mode wrongly drops or re-drives the level line. Consecutive raises in message mode show whether each raise pulses, or only the first.

// File: rtl/intr_agg_pkg.sv
// Package: shared constants for the interrupt status aggregator.
// Assumes byte offsets inside a 1 MiB register window.
package intr_agg_pkg;
    localparam int STAT_W     = 32;
    localparam int ADDR_W     = 20;
    localparam int NUM_UNITS  = 3;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 20'h00024;
    localparam logic [ADDR_W-1:0] OFS_SET    = 20'h00060;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 20'h00064;
    localparam int CALC_BIT   = 0;
    localparam int COPY_BIT   = 8;
endpackage

// File: rtl/intr_wr_decode.sv
// Module: decodes register writes into software set/clear masks and events.
// Assumes a single-cycle write strobe; other offsets are ignored.
module intr_wr_decode #(
    parameter int ADDR_W = 20,
    parameter int W      = 32,
    parameter logic [ADDR_W-1:0] SET_OFS = '0,
    parameter logic [ADDR_W-1:0] CLR_OFS = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      sw_set_mask,
    output logic [W-1:0]      sw_clr_mask,
    output logic              sw_raise,
    output logic              sw_clear
);
    // Match the write offset against the set and clear registers
    always_comb begin
        sw_raise    = wr_en && (wr_addr == SET_OFS);
        sw_clear    = wr_en && (wr_addr == CLR_OFS);
        sw_set_mask = sw_raise ? wr_data : '0;
        sw_clr_mask = sw_clear ? wr_data : '0;
    end
endmodule

// File: rtl/intr_src_merge.sv
// Module: ORs the set masks of all internal units plus the two named
// completion strobes into one hardware set mask.
// Assumes the strobes are one-cycle events.
module intr_src_merge #(
    parameter int W         = 32,
    parameter int NUM_UNITS = 3,
    parameter int CALC_BIT  = 0,
    parameter int COPY_BIT  = 8
) (
    input  logic [NUM_UNITS*W-1:0] unit_set,
    input  logic                   calc_done,
    input  logic                   copy_done,
    output logic [W-1:0]           hw_set_mask,
    output logic                   hw_raise
);
    logic [W-1:0] partial [NUM_UNITS+1];
    logic [W-1:0] named_mask;

    // Place the named strobes at their fixed bit positions
    always_comb begin
        named_mask           = '0;
        named_mask[CALC_BIT] = calc_done;
        named_mask[COPY_BIT] = copy_done;
    end

    assign partial[0] = named_mask;

    // Chain one OR stage per internal unit
    genvar u;
    generate
        for (u = 0; u < NUM_UNITS; u++) begin : g_unit
            assign partial[u+1] = partial[u] | unit_set[u*W +: W];
        end
    endgenerate

    assign hw_set_mask = partial[NUM_UNITS];
    assign hw_raise    = |hw_set_mask;
endmodule

// File: rtl/intr_status_reg.sv
// Module: holds the cause word, applying clear first and then set.
// Assumes synchronous active-low reset.
module intr_status_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] set_mask,
    output logic [W-1:0] status_nxt,
    output logic [W-1:0] status_q
);
    // Next value: clear wins over the old bit, set wins over clear
    assign status_nxt = (status_q & ~clr_mask) | set_mask;

    // Register the cause word
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_nxt;
    end
endmodule

// File: rtl/intr_notify.sv
// Module: drives the level line and the message pulse from raise/clear
// events and the zero state of the next cause word.
// Assumes mode input is static around events of interest; level holds in message mode.
module intr_notify (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clear,
    input  logic nxt_zero,
    input  logic msi_en,
    output logic irq_level,
    output logic msi_pulse
);
    // Update the level line: raise asserts, emptying clear deasserts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= 1'b0;
        end else if (!msi_en) begin
            if (raise && !nxt_zero)     irq_level <= 1'b1;
            else if (clear && nxt_zero) irq_level <= 1'b0;
        end
    end

    // Emit one message pulse per raise that leaves the word nonzero
    always_ff @(posedge clk) begin
        if (!rst_n) msi_pulse <= 1'b0;
        else        msi_pulse <= msi_en && raise && !nxt_zero;
    end
endmodule

// File: rtl/intr_status_agg.sv
// Module: top of the interrupt status aggregator. Merges software and
// internal set/clear masks into a cause word and signals the host by
// level or by message pulse.
// Assumes one register write per cycle and a combinational read port.
module intr_status_agg
    import intr_agg_pkg::*;
#(
    parameter int W         = STAT_W,
    parameter int AW        = ADDR_W,
    parameter int UNITS     = NUM_UNITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [W-1:0]     rd_data,
    input  logic             calc_done,
    input  logic             copy_done,
    input  logic [UNITS*W-1:0] unit_set,
    input  logic             msi_en,
    output logic             irq_level,
    output logic             msi_pulse
);
    logic [W-1:0] sw_set_mask, sw_clr_mask, hw_set_mask;
    logic [W-1:0] status_nxt, status_q;
    logic         sw_raise, sw_clear, hw_raise;

    intr_wr_decode #(
        .ADDR_W(AW), .W(W),
        .SET_OFS(OFS_SET[AW-1:0]), .CLR_OFS(OFS_CLR[AW-1:0])
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sw_set_mask(sw_set_mask), .sw_clr_mask(sw_clr_mask),
        .sw_raise(sw_raise), .sw_clear(sw_clear)
    );

    intr_src_merge #(
        .W(W), .NUM_UNITS(UNITS), .CALC_BIT(CALC_BIT), .COPY_BIT(COPY_BIT)
    ) u_merge (
        .unit_set(unit_set), .calc_done(calc_done), .copy_done(copy_done),
        .hw_set_mask(hw_set_mask), .hw_raise(hw_raise)
    );

    intr_status_reg #(.W(W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .clr_mask(sw_clr_mask), .set_mask(sw_set_mask | hw_set_mask),
        .status_nxt(status_nxt), .status_q(status_q)
    );

    intr_notify u_ntf (
        .clk(clk), .rst_n(rst_n),
        .raise(sw_raise | hw_raise), .clear(sw_clear),
        .nxt_zero(status_nxt == '0), .msi_en(msi_en),
        .irq_level(irq_level), .msi_pulse(msi_pulse)
    );

    // Read mux: cause word at the status offset, all ones elsewhere
    assign rd_data = (rd_addr == OFS_STATUS[AW-1:0]) ? status_q : '1;
endmodule

// File: rtl/intr_status_agg_chk.sv
// Checker: temporal properties of the aggregator, bound to the top.
module intr_status_agg_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         msi_en,
    input logic         irq_level,
    input logic         msi_pulse,
    input logic [W-1:0] status_q
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && !irq_level && !msi_pulse));

    // R7
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_level) |-> (status_q != '0 && $past(!msi_en)));

    // R8
    level_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_level) |-> (status_q == '0 && $past(!msi_en)));

    // R9
    pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> (status_q != '0 && $past(msi_en)));

    // R9
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(msi_en) |-> $stable(irq_level));
endmodule

bind intr_status_agg intr_status_agg_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en),
    .irq_level(irq_level), .msi_pulse(msi_pulse), .status_q(status_q)
);

// File: tb/intr_status_agg_tb.sv
module intr_status_agg_tb;
    localparam int W = 32;
    localparam int AW = 20;
    localparam int U = 3;

    typedef struct {
        logic [W-1:0] stat;
        logic         lvl;
        logic         pls;
        string        req;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = 20'h24;
    logic [W-1:0]  wr_data = '0, rd_data;
    logic calc_done = 0, copy_done = 0, msi_en = 0;
    logic [U*W-1:0] unit_set = '0;
    logic irq_level, msi_pulse;

    int total = 0, bad = 0;
    exp_t q[$];
    logic [W-1:0] m_stat = '0;
    logic m_lvl = 0;

    always #2 clk = ~clk;

    intr_status_agg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .calc_done(calc_done), .copy_done(copy_done), .unit_set(unit_set),
        .msi_en(msi_en), .irq_level(irq_level), .msi_pulse(msi_pulse)
    );

    // Driver: apply one cycle of stimulus and push the expected outcome
    task automatic step(input logic we, input logic [AW-1:0] a,
                        input logic [W-1:0] d, input logic cd, input logic pd,
                        input logic [U*W-1:0] us, input logic me, input string req);
        logic [W-1:0] setm, clrm, nxt;
        logic raise, clr, pls;
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; calc_done = cd;
        copy_done = pd; unit_set = us; msi_en = me;
        clrm = (we && a == 20'h64) ? d : '0;
        setm = (we && a == 20'h60) ? d : '0;
        setm[0] = setm[0] | cd;
        setm[8] = setm[8] | pd;
        for (int i = 0; i < U; i++) setm = setm | us[i*W +: W];
        raise = (we && a == 20'h60) || (setm != '0);
        clr = we && a == 20'h64;
        nxt = (m_stat & ~clrm) | setm;
        pls = me && raise && nxt != '0;
        if (!me) begin
            if (raise && nxt != '0) m_lvl = 1'b1;
            else if (clr && nxt == '0) m_lvl = 1'b0;
        end
        m_stat = nxt;
        e.stat = nxt; e.lvl = m_lvl; e.pls = pls; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input logic me);
        step(1'b0, '0, '0, 1'b0, 1'b0, '0, me, "R10");
    endtask

    // Monitor: compare each result just after the edge that produced it
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (rd_data !== e.stat || irq_level !== e.lvl || msi_pulse !== e.pls) begin
                bad++;
                $display("FAIL %s: got stat=%h lvl=%b pls=%b exp stat=%h lvl=%b pls=%b",
                         e.req, rd_data, irq_level, msi_pulse, e.stat, e.lvl, e.pls);
            end
        end
    end

    task automatic direct(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        direct(rd_data, '0, "R1");
        direct({31'b0, irq_level}, '0, "R1");
        direct({31'b0, msi_pulse}, '0, "R1");
        // R3 set and OR-merge, R7 level assert
        step(1, 20'h60, 32'h5, 0, 0, '0, 0, "R3");
        step(1, 20'h60, 32'h30, 0, 0, '0, 0, "R3");
        // R8 partial clear keeps level
        step(1, 20'h64, 32'h1, 0, 0, '0, 0, "R8");
        // R4 full clear drops level
        step(1, 20'h64, 32'hFFFF_FFFF, 0, 0, '0, 0, "R4");
        // R5 internal sources
        step(0, '0, '0, 1, 0, '0, 0, "R5");
        step(0, '0, '0, 0, 1, '0, 0, "R5");
        step(0, '0, '0, 0, 0, {32'h8000_0000, 32'h0, 32'h0}, 0, "R5");
        // R6 clear and set same bit, same cycle
        step(1, 20'h64, 32'h0000_0001, 1, 0, '0, 0, "R6");
        step(1, 20'h64, 32'h0000_0100, 0, 0, {32'h0, 32'h0100, 32'h0}, 0, "R6");
        // R10 write to unrelated offset
        step(1, 20'h68, 32'hFFFF_FFFF, 0, 0, '0, 0, "R10");
        step(1, 20'h24, 32'hFFFF_FFFF, 0, 0, '0, 0, "R10");
        // Empty the word, then message mode
        step(1, 20'h64, 32'hFFFF_FFFF, 0, 0, '0, 0, "R4");
        idle(1);
        // R9 pulses on each raise, back to back
        step(1, 20'h60, 32'h2, 0, 0, '0, 1, "R9");
        step(0, '0, '0, 1, 0, '0, 1, "R9");
        step(1, 20'h64, 32'hFFFF_FFFF, 0, 0, '0, 1, "R9");
        // R11 zero raise on empty word
        step(1, 20'h60, 32'h0, 0, 0, '0, 1, "R11");
        step(1, 20'h60, 32'h0, 0, 0, '0, 0, "R11");
        // R9 level held while in message mode
        step(1, 20'h60, 32'h4, 0, 0, '0, 0, "R7");
        step(1, 20'h64, 32'hFFFF_FFFF, 0, 0, '0, 1, "R9");
        idle(1);
        // R8 emptying clear in level mode drops the held line
        step(1, 20'h64, 32'h0, 0, 0, '0, 0, "R8");
        step(0, '0, '0, 0, 0, {32'h0, 32'h0, 32'h00C0_0000}, 0, "R5");
        idle(0);
        @(negedge clk);
        @(negedge clk);
        // R2 read mux
        direct(rd_data, 32'h00C0_0000, "R2");
        rd_addr = 20'h20;
        #1 direct(rd_data, 32'hFFFF_FFFF, "R2");
        rd_addr = 20'h60;
        #1 direct(rd_data, 32'hFFFF_FFFF, "R2");
        rd_addr = 20'h24;
        #1 direct(rd_data, 32'h00C0_0000, "R2");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule